// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block is the bus interface of a small processor core that talks to memory and I/O over one set of pins. Those pins carry the address and the data at different times. An internal requester offers one access at a time: a 20-bit address, a direction, a memory/I/O select, a word/byte hint and write data. The block turns that access into a bus cycle of four clock periods, T1 through T4. It drives the address latch strobe, the read, write and data-enable strobes, the direction line and the memory/I/O line. It also drives the shared lines with an explicit output enable, so that an external latch and transceivers can separate address from data.

The external device slows a cycle by holding READY low. The sampled value chooses between a wait period and T3. On a read, the block captures the bus at the end of T3 and hands the data back with a one-cycle valid pulse. After the address has gone out, the upper four lines show status: a constant zero, the interrupt-enable flag, and a two-bit segment code. An external master can ask for the bus with HOLD. The block finishes any cycle in flight, releases its pins and acknowledges. It gives the bus back one clock after the request goes away.

Top module: `mux_bus_seq`

## Requirements
- R1: With READY high at every sample, a cycle lasts exactly four clocks (T1, T2, T3, T4). ALE is high in T1 only, for a single clock.
- R2: In T1, adOut carries address bits 15:0 with adOe high, and addrHi carries address bits 19:16. mIo is 1 for a memory access and 0 for an I/O access, and it holds that value from T1 through T4.
- R3: From T2 through T3, denN is low and exactly one of rdN (read) or wrN (write) is low. On a write, adOut carries the write data with adOe high. On a read, adOe is low.
- R4: READY is sampled on the clock edge that ends T2 and on the edge that ends each wait period. A low sample adds one more wait period, and the strobes stay active through all wait periods. The cycle therefore lasts 4 + N clocks for N low samples.
- R5: On a read, the value on adIn at the edge that ends T3 appears on rdData. rdValid is high for exactly the one clock of T4. A write produces no rdValid.
- R6: dtR is 1 from T1 through T4 of a write and 0 from T1 through T4 of a read. In T4 all strobes (rdN, wrN, denN) are inactive, that is, high.
- R7: From T2 through T4, addrHi carries status: bit 3 is 0, bit 2 is the interrupt-enable input captured with the request, and bits 1:0 are the segment code captured with the request.
- R8: A HOLD that rises during a cycle lets that cycle complete normally. After T4, hlda is 1, adOe, addrOe and ctrlOe are 0, and ale is 0. While hlda is 1, a pending request is not acknowledged.
- R9: HOLD is sampled only in idle or in T4. hlda falls on the first clock edge at which HOLD is sampled low.
- R10: bheN is low in T1 when the request is a word access or the address is odd (bit 0 = 1). It is high otherwise, and it is high outside T1.
- R11: reqAck is high, in the same clock, when reqValid is high, the unit is idle or in T4, and HOLD is low. The request is taken on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Requester offers an access |
| reqAck | output | 1 | Access taken on this edge |
| reqAddr | input | 20 | Access address |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqIo | input | 1 | 1 = I/O space, 0 = memory |
| reqWord | input | 1 | Access uses the upper data byte |
| reqWdata | input | 16 | Write data |
| reqIntEn | input | 1 | Interrupt-enable flag for status |
| reqSeg | input | 2 | Segment code for status |
| rdData | output | 16 | Captured read data |
| rdValid | output | 1 | rdData valid (one clock) |
| adOut | output | 16 | Shared address/data lines, driven value |
| adIn | input | 16 | Shared address/data lines, received value |
| adOe | output | 1 | Drive enable for adOut |
| addrHi | output | 4 | Upper address, then status |
| addrOe | output | 1 | Drive enable for addrHi and bheN |
| bheN | output | 1 | Upper-byte enable, active low |
| ale | output | 1 | Address latch strobe |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |
| mIo | output | 1 | 1 = memory, 0 = I/O |
| dtR | output | 1 | 1 = transmit, 0 = receive |
| denN | output | 1 | Data buffer enable, active low |
| ctrlOe | output | 1 | Drive enable for rdN, wrN, mIo, dtR, denN |
| ready | input | 1 | Device ready |
| hold | input | 1 | Bus request from another master |
| hlda | output | 1 | Bus released |

## Verification
The hardest condition to reach is a HOLD that arrives in the middle of a stretched cycle. The bus must not be released early, and the acknowledge must come only after T4. The stimulus starts a read, raises HOLD in T2 and holds READY low for two samples. It then checks that the strobes stay active through the wait periods and T3, that hlda is still low in T4, and that every enable is low one clock later. A request is then held pending while hlda is high, to show that it is not taken. A scoreboard queue pairs each read's expected data, computed from its address, with the rdValid pulse, so that lost or repeated captures show up as mismatches.

// File: rtl/mux_bus_seq_pkg.sv
package mux_bus_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_T1,
    PH_T2,
    PH_TW,
    PH_T3,
    PH_T4,
    PH_HOLD
  } phase_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;        // take a new request this edge
    logic addrPhase;   // T1
    logic strobePhase; // T2, Tw, T3
    logic inCycle;     // T1..T4
    logic capture;     // last clock of T3
    logic busFloat;    // bus released to another master
  } seq_stb_t;

endpackage

// File: rtl/mux_bus_seq_ctrl.sv
module mux_bus_seq_ctrl
  import mux_bus_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     ready,
  input  logic     hold,
  output logic     reqAck,
  output logic     hlda,
  output seq_stb_t stb
);

  phase_t state, nextState;
  logic   canStart;

  assign canStart = (state == PH_IDLE) || (state == PH_T4);
  assign reqAck   = canStart && reqValid && !hold;

  always_comb begin
    nextState = state;
    case (state)
      PH_IDLE, PH_T4: begin
        if (hold)          nextState = PH_HOLD;
        else if (reqValid) nextState = PH_T1;
        else               nextState = PH_IDLE;
      end
      PH_T1:        nextState = PH_T2;
      PH_T2, PH_TW: nextState = ready ? PH_T3 : PH_TW;
      PH_T3:        nextState = PH_T4;
      PH_HOLD:      nextState = hold ? PH_HOLD : PH_IDLE;
      default:      nextState = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= PH_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    stb.load        = reqAck;
    stb.addrPhase   = (state == PH_T1);
    stb.strobePhase = (state == PH_T2) || (state == PH_TW) || (state == PH_T3);
    stb.inCycle     = (state != PH_IDLE) && (state != PH_HOLD);
    stb.capture     = (state == PH_T3);
    stb.busFloat    = (state == PH_HOLD);
  end

  assign hlda = (state == PH_HOLD);

  // R11: no request is taken while the bus is released
  a_r11_no_ack_in_hold: assert property (@(posedge clk) disable iff (!rstN)
    hlda |-> !reqAck);

endmodule

// File: rtl/mux_bus_seq_path.sv
module mux_bus_seq_path
  import mux_bus_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int SEG_W  = 2,
  localparam int HI_W  = ADDR_W - DATA_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  seq_stb_t          stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              reqIo,
  input  logic              reqWord,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              reqIntEn,
  input  logic [SEG_W-1:0]  reqSeg,
  input  logic [DATA_W-1:0] adIn,
  output logic [DATA_W-1:0] adOut,
  output logic              adOe,
  output logic [HI_W-1:0]   addrHi,
  output logic              addrOe,
  output logic              bheN,
  output logic              ale,
  output logic              rdN,
  output logic              wrN,
  output logic              mIo,
  output logic              dtR,
  output logic              denN,
  output logic              ctrlOe,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  logic [ADDR_W-1:0] curAddr;
  logic [DATA_W-1:0] curWdata;
  logic              curWrite, curIo, curWord, curIntEn;
  logic [SEG_W-1:0]  curSeg;
  logic [HI_W-1:0]   statusWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr  <= '0;
      curWdata <= '0;
      curWrite <= 1'b0;
      curIo    <= 1'b0;
      curWord  <= 1'b0;
      curIntEn <= 1'b0;
      curSeg   <= '0;
    end else if (stb.load) begin
      curAddr  <= reqAddr;
      curWdata <= reqWdata;
      curWrite <= reqWrite;
      curIo    <= reqIo;
      curWord  <= reqWord;
      curIntEn <= reqIntEn;
      curSeg   <= reqSeg;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= stb.capture && !curWrite;
      if (stb.capture && !curWrite) rdData <= adIn;
    end
  end

  always_comb begin
    statusWord = '0;
    statusWord[SEG_W-1:0] = curSeg;
    statusWord[SEG_W]     = curIntEn;
  end

  assign ale    = stb.addrPhase;
  assign adOe   = !stb.busFloat && (stb.addrPhase || (stb.inCycle && curWrite));
  assign adOut  = stb.addrPhase ? curAddr[DATA_W-1:0] : curWdata;
  assign addrOe = !stb.busFloat;
  assign addrHi = stb.addrPhase ? curAddr[ADDR_W-1:DATA_W] : statusWord;
  assign bheN   = !(stb.addrPhase && (curWord || curAddr[0]));
  assign ctrlOe = !stb.busFloat;
  assign rdN    = !(stb.strobePhase && !curWrite);
  assign wrN    = !(stb.strobePhase && curWrite);
  assign denN   = !stb.strobePhase;
  assign dtR    = stb.inCycle ? curWrite : 1'b1;
  assign mIo    = stb.inCycle ? !curIo : 1'b1;

  // R3: read and write strobes never overlap
  a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !wrN));

  // R5: read data valid only right after an active read strobe
  a_r5_valid_after_read: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(!rdN));

  // R6: direction does not change once the address has gone out
  a_r6_dtr_steady: assert property (@(posedge clk) disable iff (!rstN)
    (stb.inCycle && !stb.addrPhase) |-> $stable(dtR));

endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import mux_bus_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int SEG_W  = 2,
  localparam int HI_W  = ADDR_W - DATA_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqAck,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic              reqIo,
  input  logic              reqWord,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              reqIntEn,
  input  logic [SEG_W-1:0]  reqSeg,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic [DATA_W-1:0] adOut,
  input  logic [DATA_W-1:0] adIn,
  output logic              adOe,
  output logic [HI_W-1:0]   addrHi,
  output logic              addrOe,
  output logic              bheN,
  output logic              ale,
  output logic              rdN,
  output logic              wrN,
  output logic              mIo,
  output logic              dtR,
  output logic              denN,
  output logic              ctrlOe,
  input  logic              ready,
  input  logic              hold,
  output logic              hlda
);

  seq_stb_t stb;

  mux_bus_seq_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .ready    (ready),
    .hold     (hold),
    .reqAck   (reqAck),
    .hlda     (hlda),
    .stb      (stb)
  );

  mux_bus_seq_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEG_W(SEG_W)) i_path (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .reqAddr  (reqAddr),
    .reqWrite (reqWrite),
    .reqIo    (reqIo),
    .reqWord  (reqWord),
    .reqWdata (reqWdata),
    .reqIntEn (reqIntEn),
    .reqSeg   (reqSeg),
    .adIn     (adIn),
    .adOut    (adOut),
    .adOe     (adOe),
    .addrHi   (addrHi),
    .addrOe   (addrOe),
    .bheN     (bheN),
    .ale      (ale),
    .rdN      (rdN),
    .wrN      (wrN),
    .mIo      (mIo),
    .dtR      (dtR),
    .denN     (denN),
    .ctrlOe   (ctrlOe),
    .rdData   (rdData),
    .rdValid  (rdValid)
  );

  // R1: the latch strobe lasts one clock
  a_r1_ale_pulse: assert property (@(posedge clk) disable iff (!rstN)
    ale |=> !ale);

  // R8: a released bus drives nothing but a low ALE
  a_r8_float: assert property (@(posedge clk) disable iff (!rstN)
    hlda |-> (!adOe && !addrOe && !ctrlOe && !ale));

  // R9: acknowledge drops on the first edge that sees HOLD low
  a_r9_release: assert property (@(posedge clk) disable iff (!rstN)
    (hlda && !hold) |=> !hlda);

endmodule

// File: tb/test_mux_bus_seq.sv
`timescale 1ns/1ps
module test_mux_bus_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqIo = 1'b0, reqWord = 1'b0;
  logic        reqIntEn = 1'b0;
  logic [1:0]  reqSeg = 2'd0;
  logic [19:0] reqAddr = '0;
  logic [15:0] reqWdata = '0, adIn = '0;
  logic        ready = 1'b1, hold = 1'b0;
  logic        reqAck, rdValid, adOe, addrOe, bheN, ale, rdN, wrN, mIo, dtR, denN;
  logic        ctrlOe, hlda;
  logic [15:0] rdData, adOut;
  logic [3:0]  addrHi;

  int tests = 0;
  int fails = 0;
  logic [15:0] expQ[$];

  always #5 clk = ~clk;

  mux_bus_seq i_mux_bus_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAck(reqAck),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqIo(reqIo), .reqWord(reqWord),
    .reqWdata(reqWdata), .reqIntEn(reqIntEn), .reqSeg(reqSeg),
    .rdData(rdData), .rdValid(rdValid), .adOut(adOut), .adIn(adIn),
    .adOe(adOe), .addrHi(addrHi), .addrOe(addrOe), .bheN(bheN), .ale(ale),
    .rdN(rdN), .wrN(wrN), .mIo(mIo), .dtR(dtR), .denN(denN), .ctrlOe(ctrlOe),
    .ready(ready), .hold(hold), .hlda(hlda)
  );

  function automatic logic [15:0] devData(input logic [19:0] a);
    return a[15:0] ^ 16'hA5C3 ^ {a[19:16], 12'h000};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) chk(1'b0, "R5", "unexpected rdValid", 32'(rdData), 32'h0);
      else begin
        logic [15:0] e;
        e = expQ.pop_front();
        chk(rdData == e, "R5", "read data", 32'(rdData), 32'(e));
      end
    end
  end

  task automatic runCycle(input logic [19:0] a, input bit wr, input bit io,
                          input bit word, input logic [15:0] wd, input int waits,
                          input bit ie, input logic [1:0] seg, input bit holdMid);
    logic [3:0] st;
    st = {1'b0, ie, seg};
    if (!wr) expQ.push_back(devData(a));
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqWrite = wr; reqIo = io; reqWord = word;
    reqWdata = wd; reqIntEn = ie; reqSeg = seg;
    #1 chk(reqAck == 1'b1, "R11", "reqAck", 32'(reqAck), 32'h1);
    @(negedge clk); // T1
    reqValid = 1'b0;
    chk(ale == 1'b1, "R1", "ale in T1", 32'(ale), 32'h1);
    chk(adOe && adOut == a[15:0], "R2", "address low", 32'(adOut), 32'(a[15:0]));
    chk(addrHi == a[19:16], "R2", "address high", 32'(addrHi), 32'(a[19:16]));
    chk(mIo == !io, "R2", "mIo", 32'(mIo), 32'(!io));
    chk(bheN == !(word || a[0]), "R10", "bheN in T1", 32'(bheN), 32'(!(word || a[0])));
    chk(dtR == wr, "R6", "dtR in T1", 32'(dtR), 32'(wr));
    @(negedge clk); // T2
    if (holdMid) hold = 1'b1;
    ready = (waits == 0);
    adIn = devData(a);
    chk(ale == 1'b0, "R1", "ale after T1", 32'(ale), 32'h0);
    chk(denN == 1'b0 && rdN == wr && wrN == !wr, "R3", "strobes in T2",
        32'({denN, rdN, wrN}), 32'({1'b0, wr, !wr}));
    if (wr) chk(adOe && adOut == wd, "R3", "write data", 32'(adOut), 32'(wd));
    else    chk(adOe == 1'b0, "R3", "read release", 32'(adOe), 32'h0);
    chk(addrHi == st, "R7", "status", 32'(addrHi), 32'(st));
    chk(bheN == 1'b1, "R10", "bheN after T1", 32'(bheN), 32'h1);
    for (int i = 0; i < waits; i++) begin
      @(negedge clk); // Tw
      ready = (i == waits - 1);
      chk(denN == 1'b0 && rdN == wr && wrN == !wr, "R4", "strobes in wait",
          32'({denN, rdN, wrN}), 32'({1'b0, wr, !wr}));
    end
    @(negedge clk); // T3
    ready = 1'b1;
    chk(denN == 1'b0 && ale == 1'b0, "R4", "T3 strobe", 32'({denN, ale}), 32'h0);
    chk(dtR == wr && mIo == !io, "R6", "dtR in T3", 32'({dtR, mIo}), 32'({wr, !io}));
    @(negedge clk); // T4
    chk(rdN && wrN && denN, "R6", "strobes off in T4", 32'({rdN, wrN, denN}), 32'h7);
    chk(dtR == wr && mIo == !io, "R6", "dtR in T4", 32'({dtR, mIo}), 32'({wr, !io}));
    chk(addrHi == st, "R7", "status in T4", 32'(addrHi), 32'(st));
    if (holdMid) chk(hlda == 1'b0, "R8", "no early hlda", 32'(hlda), 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "R1", "watchdog", 32'h0, 32'h1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ale == 0 && rdN && wrN && denN && !hlda && !rdValid, "R1", "reset state",
        32'({ale, rdN, wrN, denN, hlda, rdValid}), 32'b011100);
    rstN = 1'b1;
    @(negedge clk);
    // plain reads and writes, no waits
    runCycle(20'hABCD4, 1'b0, 1'b0, 1'b1, 16'h0, 0, 1'b1, 2'd2, 1'b0);
    runCycle(20'h31235, 1'b1, 1'b0, 1'b0, 16'h5A17, 0, 1'b0, 2'd1, 1'b0);
    runCycle(20'h00082, 1'b0, 1'b1, 1'b0, 16'h0, 0, 1'b0, 2'd3, 1'b0);
    runCycle(20'hF0F01, 1'b1, 1'b1, 1'b0, 16'hC3C3, 0, 1'b1, 2'd0, 1'b0);
    // wait states
    runCycle(20'h12346, 1'b0, 1'b0, 1'b1, 16'h0, 1, 1'b1, 2'd1, 1'b0);
    runCycle(20'h9ABC8, 1'b1, 1'b0, 1'b1, 16'hBEEF, 3, 1'b0, 2'd2, 1'b0);
    // hold arriving mid-cycle with waits
    runCycle(20'h55550, 1'b0, 1'b0, 1'b0, 16'h0, 2, 1'b1, 2'd3, 1'b1);
    @(negedge clk);
    chk(hlda == 1'b1, "R8", "hlda after T4", 32'(hlda), 32'h1);
    chk(!adOe && !addrOe && !ctrlOe && !ale, "R8", "bus floated",
        32'({adOe, addrOe, ctrlOe, ale}), 32'h0);
    reqValid = 1'b1; reqAddr = 20'h77777; reqWrite = 1'b0;
    #1 chk(reqAck == 1'b0, "R8", "no ack in hold", 32'(reqAck), 32'h0);
    @(negedge clk);
    chk(ale == 1'b0 && hlda == 1'b1, "R8", "request ignored", 32'({ale, hlda}), 32'b01);
    reqValid = 1'b0;
    hold = 1'b0;
    @(negedge clk);
    chk(hlda == 1'b0, "R9", "hlda released", 32'(hlda), 32'h0);
    chk(addrOe && ctrlOe, "R9", "bus driven again", 32'({addrOe, ctrlOe}), 32'h3);
    // hold from idle
    hold = 1'b1;
    @(negedge clk);
    chk(hlda == 1'b1, "R8", "hlda from idle", 32'(hlda), 32'h1);
    hold = 1'b0;
    @(negedge clk);
    chk(hlda == 1'b0, "R9", "hlda drop from idle", 32'(hlda), 32'h0);
    runCycle(20'h0CAFE, 1'b0, 1'b0, 1'b0, 16'h0, 0, 1'b0, 2'd0, 1'b0);
    repeat (3) @(negedge clk);
    chk(expQ.size() == 0, "R5", "scoreboard drained", 32'(expQ.size()), 32'h0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule